// File: doc/BRIEF.md
# Trivium Keystream Generator Core

This core produces the keystream of the Trivium synchronous stream cipher. Its 288-bit state is held in three nonlinear feedback shift registers of 93, 84 and 111 bits. A one-cycle load strobe captures an 80-bit key and an IV of up to 80 bits. The core then runs 1152 silent rounds on its own. After that it presents keystream words on a valid/ready handshake.

A compile-time parameter sets how many rounds are computed per clock, from 1 to 64, and that is also the width of the output word. Each word holds consecutive keystream bits with the earliest bit in bit 0. For a width that is a multiple of eight, the word is therefore a run of little-endian keystream bytes.

A second parameter sets the keystream budget per key/IV pair as a power of two, up to 2^64 bits. When that budget is used, the core stops output and raises a spent flag until the next load. Combining the keystream with plaintext is left to the surrounding logic.

Top module: `trivium_keystream`

## Requirements
- R1: At load, register A (93 bits, position 1 newest) takes key bit k(80-m) at position m for m = 1..80, with the key port's bit j carrying k_j, and zeros at positions 81..93. Register B (84 bits) takes IV bit v(IVW-m) at position m for m = 1..IVW, with the IV port's bit j carrying v_j, and zeros elsewhere. Register C (111 bits) is zero except positions 109, 110 and 111, which are 1.
- R2: Each round shifts one new bit into position 1 of every register. The new A bit is c66^c111^(c110&c109)^a69. The new B bit is a66^a93^(a92&a91)^b78. The new C bit is b69^b84^(b83&b82)^c87. Here xN is the bit at position N before the round.
- R3: Each round yields keystream bit c66^c111^a66^a93^b69^b84, taken from the state before that round.
- R4: After a load, exactly 1152 rounds run before any output, which takes 1152/P clock cycles. ksValid stays low during that time and rises on the cycle the warm-up completes.
- R5: P (1, 2, 4, 8, 16, 32 or 64) rounds are performed per transfer. Bit j of ksWord is the keystream bit of the j-th of those rounds, so with P = 8 each word is keystream byte R[i] with bit j equal to r[8i+j].
- R6: The state advances during output only on a clock edge with ksValid and ksReady both high.
- R7: While ksValid is high and ksReady is low, ksValid and ksWord hold their values.
- R8: A load strobe in any phase, including warm-up or output, clears ksValid and spent on the next cycle, reloads the state and restarts the warm-up count.
- R9: After 2^LIMIT_LOG2 keystream bits have been transferred, spent goes high and ksValid goes low. Both stay that way until the next load.
- R10: After reset, ksValid and spent are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Strobe: capture key and IV, start warm-up |
| key | input | 80 | Key, bit j is k_j |
| iv | input | IV_W | IV, bit j is v_j |
| ksReady | input | 1 | Consumer accepts the current word |
| ksValid | output | 1 | ksWord holds a keystream word |
| ksWord | output | P | P keystream bits, earliest in bit 0 |
| spent | output | 1 | Keystream budget for this key/IV used up |

## Verification
On every cycle, assertions check the following:
- A load clears the output on the next cycle.
- A stalled word holds steady.
- Spent excludes valid and persists until a load.
- The state moves only on a load or a step.
- The output rises exactly 1152/P cycles after the last load, which a separate counter tracks.

Only the bench's scenarios can show that the keystream bits themselves are right. It compares every word against a bit-level model of the load layout, the feedback and output equations and the bit order within a word. It does so for several keys and IVs, under irregular back-pressure, after an aborted warm-up, and up to and past the budget limit.

// File: rtl/trivium_pkg.sv
package trivium_pkg;

  localparam int LEN_A = 93;
  localparam int LEN_B = 84;
  localparam int LEN_C = 111;
  localparam int KEY_W = 80;
  localparam int WARM_ROUNDS = 4 * (LEN_A + LEN_B + LEN_C);

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } dpCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WARM,
    ST_RUN,
    ST_SPENT
  } phase_t;

endpackage

// File: rtl/trivium_round.sv
module trivium_round
  import trivium_pkg::*;
(
  input  logic [LEN_A:1] aIn,
  input  logic [LEN_B:1] bIn,
  input  logic [LEN_C:1] cIn,
  output logic [LEN_A:1] aOut,
  output logic [LEN_B:1] bOut,
  output logic [LEN_C:1] cOut,
  output logic           rBit
);

  logic tapA, tapB, tapC;
  logic newA, newB, newC;

  // linear part of each register's contribution; position 1 is newest
  assign tapA = aIn[66] ^ aIn[93];
  assign tapB = bIn[69] ^ bIn[84];
  assign tapC = cIn[66] ^ cIn[111];

  assign newA = tapC ^ (cIn[110] & cIn[109]) ^ aIn[69];
  assign newB = tapA ^ (aIn[92] & aIn[91]) ^ bIn[78];
  assign newC = tapB ^ (bIn[83] & bIn[82]) ^ cIn[87];

  assign rBit = tapA ^ tapB ^ tapC;

  assign aOut = {aIn[LEN_A-1:1], newA};
  assign bOut = {bIn[LEN_B-1:1], newB};
  assign cOut = {cIn[LEN_C-1:1], newC};

endmodule

// File: rtl/trivium_datapath.sv
module trivium_datapath
  import trivium_pkg::*;
#(
  parameter int P    = 8,
  parameter int IV_W = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpCtl_t           ctl,
  input  logic [KEY_W-1:0] key,
  input  logic [IV_W-1:0]  iv,
  output logic [P-1:0]     ksWord
);

  logic [LEN_A:1] stA, ldA;
  logic [LEN_B:1] stB, ldB;
  logic [LEN_C:1] stC, ldC;

  logic [LEN_A:1] chA [P+1];
  logic [LEN_B:1] chB [P+1];
  logic [LEN_C:1] chC [P+1];

  // load image: newest key/IV bit at position 1
  always_comb begin
    ldA = '0;
    ldB = '0;
    ldC = '0;
    for (int m = 1; m <= KEY_W; m++) ldA[m] = key[KEY_W-m];
    for (int m = 1; m <= IV_W; m++)  ldB[m] = iv[IV_W-m];
    ldC[LEN_C:LEN_C-2] = 3'b111;
  end

  assign chA[0] = stA;
  assign chB[0] = stB;
  assign chC[0] = stC;

  for (genvar t = 0; t < P; t++) begin : g_round
    trivium_round u_round (
      .aIn (chA[t]),   .bIn (chB[t]),   .cIn (chC[t]),
      .aOut(chA[t+1]), .bOut(chB[t+1]), .cOut(chC[t+1]),
      .rBit(ksWord[t])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stA <= '0;
      stB <= '0;
      stC <= '0;
    end else if (ctl.load) begin
      stA <= ldA;
      stB <= ldB;
      stC <= ldC;
    end else if (ctl.step) begin
      stA <= chA[P];
      stB <= chB[P];
      stC <= chC[P];
    end
  end

  // R6
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.load && !ctl.step) |=> ($stable(stA) && $stable(stB) && $stable(stC)));

endmodule

// File: rtl/trivium_ctrl.sv
module trivium_ctrl
  import trivium_pkg::*;
#(
  parameter int P          = 8,
  parameter int LIMIT_LOG2 = 64
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  logic   ksReady,
  output dpCtl_t ctl,
  output logic   ksValid,
  output logic   spent
);

  localparam int WARM_CYC = WARM_ROUNDS / P;
  localparam int WC_W     = $clog2(WARM_CYC + 1);
  localparam int WORD_W   = LIMIT_LOG2 - $clog2(P);

  phase_t            phase;
  logic [WC_W-1:0]   warmCnt;
  logic [WORD_W-1:0] wordCnt;
  logic              xfer;

  assign ksValid  = (phase == ST_RUN);
  assign spent    = (phase == ST_SPENT);
  assign xfer     = ksValid && ksReady;
  assign ctl.load = load;
  assign ctl.step = (phase == ST_WARM) || xfer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= ST_IDLE;
      warmCnt <= '0;
      wordCnt <= '0;
    end else if (load) begin
      phase   <= ST_WARM;
      warmCnt <= '0;
      wordCnt <= '0;
    end else begin
      case (phase)
        ST_WARM: begin
          warmCnt <= warmCnt + 1'b1;
          if (warmCnt == WC_W'(WARM_CYC - 1)) phase <= ST_RUN;
        end
        ST_RUN: if (xfer) begin
          wordCnt <= wordCnt + 1'b1;
          if (&wordCnt) phase <= ST_SPENT;
        end
        default: ;
      endcase
    end
  end

  // R8
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!ksValid && !spent));

  // R9
  spent_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spent |-> !ksValid);

  // R9
  spent_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spent && !load) |=> spent);

endmodule

// File: rtl/trivium_keystream.sv
module trivium_keystream
  import trivium_pkg::*;
#(
  parameter int P          = 8,
  parameter int IV_W       = 80,
  parameter int LIMIT_LOG2 = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [KEY_W-1:0] key,
  input  logic [IV_W-1:0]  iv,
  input  logic             ksReady,
  output logic             ksValid,
  output logic [P-1:0]     ksWord,
  output logic             spent
);

  dpCtl_t ctl;

  trivium_ctrl #(.P(P), .LIMIT_LOG2(LIMIT_LOG2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load), .ksReady(ksReady),
    .ctl(ctl), .ksValid(ksValid), .spent(spent)
  );

  trivium_datapath #(.P(P), .IV_W(IV_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .key(key), .iv(iv), .ksWord(ksWord)
  );

  // independent cycle count since the last load, for the warm-up check
  localparam int WARM_CYC = WARM_ROUNDS / P;
  localparam int SL_W     = $clog2(WARM_CYC + 2) + 1;
  logic [SL_W-1:0] sinceLoad;

  always_ff @(posedge clk) begin
    if (!rst_n)                 sinceLoad <= '0;
    else if (load)              sinceLoad <= '0;
    else if (!(&sinceLoad))     sinceLoad <= sinceLoad + 1'b1;
  end

  // R4
  warm_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ksValid) |-> (sinceLoad == SL_W'(WARM_CYC)));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ksValid && !ksReady && !load) |=> (ksValid && $stable(ksWord)));

endmodule

// File: tb/test_trivium_keystream.sv
`timescale 1ns/1ps
module test_trivium_keystream;

  localparam int P = 8;
  localparam int IVW = 80;
  localparam int LIM = 7;               // 128 bits = 16 words
  localparam int WORDS = (1 << LIM) / P;
  localparam int WARM_CYC = 1152 / P;

  logic clk = 0, rst_n = 0, load = 0, ksReady = 0;
  logic [79:0] key = '0;
  logic [IVW-1:0] iv = '0;
  logic ksValid, spent;
  logic [P-1:0] ksWord;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  trivium_keystream #(.P(P), .IV_W(IVW), .LIMIT_LOG2(LIM)) i_trivium_keystream (
    .clk(clk), .rst_n(rst_n), .load(load), .key(key), .iv(iv),
    .ksReady(ksReady), .ksValid(ksValid), .ksWord(ksWord), .spent(spent)
  );

  // bit-level reference, position 1 = newest
  logic [93:1] ra;
  logic [84:1] rb;
  logic [111:1] rc;

  task automatic refRound(output logic r);
    logic na, nb, nc;
    r  = rc[66] ^ rc[111] ^ ra[66] ^ ra[93] ^ rb[69] ^ rb[84];
    na = rc[66] ^ rc[111] ^ (rc[110] & rc[109]) ^ ra[69];
    nb = ra[66] ^ ra[93] ^ (ra[92] & ra[91]) ^ rb[78];
    nc = rb[69] ^ rb[84] ^ (rb[83] & rb[82]) ^ rc[87];
    ra = {ra[92:1], na};
    rb = {rb[83:1], nb};
    rc = {rc[110:1], nc};
  endtask

  task automatic refLoad(input logic [79:0] k, input logic [IVW-1:0] v);
    logic r;
    ra = '0; rb = '0; rc = '0;
    for (int m = 1; m <= 80; m++) ra[m] = k[80-m];
    for (int m = 1; m <= IVW; m++) rb[m] = v[IVW-m];
    rc[111:109] = 3'b111;
    for (int n = 0; n < 1152; n++) refRound(r);
  endtask

  task automatic refWord(output logic [P-1:0] w);
    logic r;
    for (int j = 0; j < P; j++) begin
      refRound(r);
      w[j] = r;
    end
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doLoad(input logic [79:0] k, input logic [IVW-1:0] v);
    @(negedge clk);
    key = k; iv = v; load = 1; ksReady = 0;
    @(negedge clk);
    load = 0;
  endtask

  // returns number of negedges until valid (called right after doLoad)
  task automatic waitValid(output int n);
    n = 0;
    while (!ksValid && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // R10
  task automatic tReset();
    check("R10 valid after reset", ksValid, 0);
    check("R10 spent after reset", spent, 0);
  endtask

  // R1, R4
  task automatic tWarm(input logic [79:0] k, input logic [IVW-1:0] v);
    int n;
    doLoad(k, v);
    check("R8 valid low after load", ksValid, 0);
    waitValid(n);
    check("R4 warm-up cycles", n, WARM_CYC);
    refLoad(k, v);
  endtask

  // R2, R3, R5, R9: full budget with ready held high
  task automatic tStream(input logic [79:0] k, input logic [IVW-1:0] v);
    logic [P-1:0] w;
    tWarm(k, v);
    for (int i = 0; i < WORDS; i++) begin
      refWord(w);
      check("R1/R2/R3/R5 keystream word", ksWord, w);
      check("R5 valid during output", ksValid, 1);
      ksReady = 1;
      @(negedge clk);
    end
    ksReady = 0;
    check("R9 spent at limit", spent, 1);
    check("R9 valid low at limit", ksValid, 0);
    ksReady = 1;
    repeat (5) @(negedge clk);
    check("R9 spent stays", spent, 1);
    check("R9 valid stays low", ksValid, 0);
    ksReady = 0;
  endtask

  // R6, R7: irregular back-pressure
  task automatic tStall(input logic [79:0] k, input logic [IVW-1:0] v);
    logic [P-1:0] w, held;
    tWarm(k, v);
    for (int i = 0; i < 10; i++) begin
      refWord(w);
      held = ksWord;
      ksReady = 0;
      for (int s = 0; s < (i % 4); s++) begin
        @(negedge clk);
        check("R7 word held while stalled", ksWord, held);
        check("R7 valid held while stalled", ksValid, 1);
      end
      check("R6 word after stall", ksWord, w);
      ksReady = 1;
      @(negedge clk);
      ksReady = 0;
    end
  endtask

  // R8: load during warm-up and during output
  task automatic tAbort();
    logic [P-1:0] w;
    int n;
    doLoad(80'h1, 80'h2);
    repeat (50) @(negedge clk);
    tWarm(80'hA5A5_5A5A_F00D_1234_5678, 80'h0BAD_CAFE_0000_FFFF_1357);
    refWord(w);
    check("R8 keystream after aborted warm-up", ksWord, w);
    ksReady = 1;
    @(negedge clk);
    ksReady = 0;
    doLoad(80'hFFFF_FFFF_FFFF_FFFF_FFFF, 80'h0);
    check("R8 valid cleared by load in output", ksValid, 0);
    check("R8 spent cleared by load", spent, 0);
    waitValid(n);
    check("R8 warm-up restarted", n, WARM_CYC);
    refLoad(80'hFFFF_FFFF_FFFF_FFFF_FFFF, 80'h0);
    refWord(w);
    check("R8 keystream after reload", ksWord, w);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1;
    @(negedge clk);
    tReset();
    tStream(80'h0, 80'h0);
    tStream(80'h0123_4567_89AB_CDEF_0F1E, 80'hFEDC_BA98_7654_3210_A1B2);
    tStall(80'h8000_0000_0000_0000_0001, 80'h3C3C_3C3C_3C3C_3C3C_3C3C);
    tAbort();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule